// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the control pins of a single-data-rate SDRAM interface and never drives them. On every rising clock edge it decodes the command on the strobe pins and publishes it one cycle later. It keeps a view of each of four banks: whether the bank is idle or holds an open row, and which row is open. Clock-count checks on these views flag commands that break the bank protocol or the minimum spacing rules.

A violation sets a bit in a sticky flag vector. A small code names the lowest-numbered violation of the most recent offending cycle. Both stay set until the synchronous clear input is raised for one cycle. The block models no data storage and looks at no data pins. It is meant to sit beside a memory controller in a simulation or emulation build, or as a protocol guard in silicon.

All spacing limits are parameters counted in clock cycles. The defaults suit a 5 ns clock: three cycles from activate to column command, two between activates of different banks, three for precharge, two after a mode load, and bursts of four beats.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A command is decoded from {rasN,casN,weN}: 000 mode load (code 1), 001 refresh (2), 011 activate (3), 101 read (4), 100 write (5), 010 precharge (6), 110 burst stop (7), 111 no-op (0). cmdCode shows the code in the cycle after the sampling edge and is 0 during reset.
- R2: With csN high or cke low, the pins are ignored. cmdCode reads 8, no flag is set, and no bank row or state changes.
- R3: Activate opens the bank selected by ba (0..3, ba[0] least significant). It marks the bank active in bankActive[ba] and stores addr in openRow[ba*ROW_W +: ROW_W].
- R4: Precharge with addr[10] low idles only the bank selected by ba. With addr[10] high it idles all banks.
- R5: Mode load or refresh while any bank is active sets flag bit 0.
- R6: Any command other than no-op that comes less than CLK_MODE2CMD cycles after a mode load sets flag bit 1. No-ops in that gap are allowed.
- R7: Read or write with addr[10] high starts an auto-precharge burst of BURST_BEATS cycles. A read or write inside that burst sets flag bit 2. The bank turns idle at the first cycle after the burst.
- R8: Activate to a bank less than CLK_PRE2ACT cycles after its precharge sets flag bit 3. For auto-precharge, the precharge is counted from the first cycle after the burst.
- R9: Read or write less than CLK_ACT2RW cycles after an activate of the same bank sets flag bit 4.
- R10: Activate of a different bank less than CLK_ACT2ACT cycles after the previous activate sets flag bit 5.
- R11: Read or write to an idle bank sets flag bit 6. Activate of an already active bank sets flag bit 7.
- R12: errFlags bits are sticky. errCode holds one plus the lowest flag index raised in the latest offending cycle. A cycle with errClr high returns both to zero, and clear wins over a new violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| errClr | input | 1 | Synchronous clear of flags and code |
| cke | input | 1 | Clock enable pin |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank select |
| addr | input | ADDR_W | Multiplexed address, bit 10 selects all-bank / auto-precharge |
| cmdCode | output | 4 | Registered decoded command |
| bankActive | output | BANKS | One bit per bank, set while a row is open |
| openRow | output | BANKS*ROW_W | Last activated row of each bank |
| errFlags | output | 8 | Sticky violation flags |
| errCode | output | 4 | Code of the latest violation, 0 for none |

## Verification
The bench builds the block with its default limits: three cycles activate-to-column, two between activates, three for precharge, two after a mode load, and four-beat bursts. These short windows let each spacing rule be hit once one cycle too early and once exactly at its boundary within a few steps. An auto-precharge burst, its idle transition and the precharge window that follows it all fit in a dozen cycles. Every bank index, the single- and all-bank precharge, and both ways of ignoring the pins are driven so that rows, states and flags can be compared cycle by cycle.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_NOP        = 4'd0,
    CMD_MODE       = 4'd1,
    CMD_REFRESH    = 4'd2,
    CMD_ACTIVATE   = 4'd3,
    CMD_READ       = 4'd4,
    CMD_WRITE      = 4'd5,
    CMD_PRECHARGE  = 4'd6,
    CMD_BURST_STOP = 4'd7,
    CMD_DESELECT   = 4'd8
  } cmd_e;

  localparam int ERR_KINDS       = 8;
  localparam int ERR_MODE_BUSY   = 0;
  localparam int ERR_MODE_GAP    = 1;
  localparam int ERR_AP_BUSY     = 2;
  localparam int ERR_PRE_GAP     = 3;
  localparam int ERR_ACT_RW_GAP  = 4;
  localparam int ERR_ACT_ACT_GAP = 5;
  localparam int ERR_RW_IDLE     = 6;
  localparam int ERR_ACT_OPEN    = 7;

  // Strobes from the decoder to the bank state file, one command per cycle.
  typedef struct packed {
    logic act;
    logic pre;
    logic preAll;
    logic rw;
    logic autoPre;
  } bank_strobe_t;

endpackage

// File: rtl/sdram_mon_ctrl.sv
module sdram_mon_ctrl
  import sdram_mon_pkg::*;
#(
  parameter int BANKS        = 4,
  parameter int BA_W         = 2,
  parameter int CLK_ACT2ACT  = 2,
  parameter int CLK_MODE2CMD = 2,
  parameter int BURST_BEATS  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 errClr,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BA_W-1:0]      ba,
  input  logic                 apBit,
  input  logic [BANKS-1:0]     bankActive,
  input  logic [BANKS-1:0]     rwHold,
  input  logic [BANKS-1:0]     actHold,
  output bank_strobe_t         strb,
  output logic [3:0]           cmdCode,
  output logic [ERR_KINDS-1:0] errFlags,
  output logic [3:0]           errCode
);

  localparam int MODE_W = $clog2(CLK_MODE2CMD + 1);
  localparam int RRD_W  = $clog2(CLK_ACT2ACT + 1);
  localparam int AP_W   = $clog2(BURST_BEATS + 1);

  cmd_e cmdNow;
  logic isRw;
  logic [MODE_W-1:0] modeWait;
  logic [RRD_W-1:0]  rrdWait;
  logic [AP_W-1:0]   apWait;
  logic [BA_W-1:0]   lastAct;
  logic [ERR_KINDS-1:0] viol;

  always_comb begin
    if (!cke || csN) begin
      cmdNow = CMD_DESELECT;
    end else begin
      case ({rasN, casN, weN})
        3'b000:  cmdNow = CMD_MODE;
        3'b001:  cmdNow = CMD_REFRESH;
        3'b011:  cmdNow = CMD_ACTIVATE;
        3'b101:  cmdNow = CMD_READ;
        3'b100:  cmdNow = CMD_WRITE;
        3'b010:  cmdNow = CMD_PRECHARGE;
        3'b110:  cmdNow = CMD_BURST_STOP;
        default: cmdNow = CMD_NOP;
      endcase
    end
  end

  assign isRw = (cmdNow == CMD_READ) || (cmdNow == CMD_WRITE);

  always_comb begin
    strb.act     = (cmdNow == CMD_ACTIVATE);
    strb.pre     = (cmdNow == CMD_PRECHARGE);
    strb.preAll  = apBit;
    strb.rw      = isRw;
    strb.autoPre = apBit;
  end

  always_comb begin
    viol = '0;
    viol[ERR_MODE_BUSY]   = ((cmdNow == CMD_MODE) || (cmdNow == CMD_REFRESH)) && (|bankActive);
    viol[ERR_MODE_GAP]    = (cmdNow != CMD_NOP) && (cmdNow != CMD_DESELECT) && (modeWait != '0);
    viol[ERR_AP_BUSY]     = isRw && (apWait != '0);
    viol[ERR_PRE_GAP]     = strb.act && actHold[ba];
    viol[ERR_ACT_RW_GAP]  = isRw && rwHold[ba];
    viol[ERR_ACT_ACT_GAP] = strb.act && (rrdWait != '0) && (ba != lastAct);
    viol[ERR_RW_IDLE]     = isRw && !bankActive[ba];
    viol[ERR_ACT_OPEN]    = strb.act && bankActive[ba];
  end

  function automatic logic [3:0] firstErr(input logic [ERR_KINDS-1:0] v);
    logic [3:0] res;
    res = '0;
    for (int i = ERR_KINDS - 1; i >= 0; i--) begin
      if (v[i]) res = 4'(i + 1);
    end
    return res;
  endfunction

  // Global spacing counters: each loaded with (limit - 1) and counted down.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeWait <= '0;
      rrdWait  <= '0;
      apWait   <= '0;
      lastAct  <= '0;
    end else begin
      if (modeWait != '0) modeWait <= modeWait - MODE_W'(1);
      if (rrdWait != '0)  rrdWait  <= rrdWait - RRD_W'(1);
      if (apWait != '0)   apWait   <= apWait - AP_W'(1);
      if (cmdNow == CMD_MODE) modeWait <= MODE_W'(CLK_MODE2CMD - 1);
      if (strb.act) begin
        rrdWait <= RRD_W'(CLK_ACT2ACT - 1);
        lastAct <= ba;
      end
      if (isRw && apBit) apWait <= AP_W'(BURST_BEATS - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdCode  <= CMD_NOP;
      errFlags <= '0;
      errCode  <= '0;
    end else begin
      cmdCode <= cmdNow;
      if (errClr) begin
        errFlags <= '0;
        errCode  <= '0;
      end else begin
        errFlags <= errFlags | viol;
        if (|viol) errCode <= firstErr(viol);
      end
    end
  end

endmodule

// File: rtl/sdram_mon_banks.sv
module sdram_mon_banks
  import sdram_mon_pkg::*;
#(
  parameter int BANKS       = 4,
  parameter int BA_W        = 2,
  parameter int ROW_W       = 13,
  parameter int CLK_ACT2RW  = 3,
  parameter int CLK_PRE2ACT = 3,
  parameter int BURST_BEATS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  bank_strobe_t           strb,
  input  logic [BA_W-1:0]        ba,
  input  logic [ROW_W-1:0]       row,
  output logic [BANKS-1:0]       bankActive,
  output logic [BANKS*ROW_W-1:0] openRow,
  output logic [BANKS-1:0]       rwHold,
  output logic [BANKS-1:0]       actHold
);

  localparam int RCD_W = $clog2(CLK_ACT2RW + 1);
  localparam int PRE_W = $clog2(BURST_BEATS + CLK_PRE2ACT + 1);
  localparam logic [RCD_W-1:0] RCD_LOAD = RCD_W'(CLK_ACT2RW - 1);
  localparam logic [PRE_W-1:0] PRE_LOAD = PRE_W'(CLK_PRE2ACT - 1);
  localparam logic [PRE_W-1:0] AP_LOAD  = PRE_W'(BURST_BEATS + CLK_PRE2ACT - 1);
  localparam logic [PRE_W-1:0] AP_END   = PRE_W'(CLK_PRE2ACT);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic sel;
    logic activeQ;
    logic closingQ;
    logic [ROW_W-1:0] rowQ;
    logic [RCD_W-1:0] rcdQ;
    logic [PRE_W-1:0] preQ;

    assign sel = (ba == BA_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        activeQ  <= 1'b0;
        closingQ <= 1'b0;
        rowQ     <= '0;
        rcdQ     <= '0;
        preQ     <= '0;
      end else begin
        if (rcdQ != '0) rcdQ <= rcdQ - RCD_W'(1);
        if (preQ != '0) preQ <= preQ - PRE_W'(1);
        // Auto-precharge burst has ended: close the bank.
        if (closingQ && (preQ == AP_END)) begin
          activeQ  <= 1'b0;
          closingQ <= 1'b0;
        end
        if (strb.act && sel) begin
          activeQ <= 1'b1;
          rowQ    <= row;
          rcdQ    <= RCD_LOAD;
        end
        if (strb.pre && (strb.preAll || sel)) begin
          activeQ  <= 1'b0;
          closingQ <= 1'b0;
          preQ     <= PRE_LOAD;
        end
        if (strb.rw && strb.autoPre && sel && activeQ) begin
          closingQ <= 1'b1;
          preQ     <= AP_LOAD;
        end
      end
    end

    assign bankActive[b]               = activeQ;
    assign openRow[b*ROW_W +: ROW_W]   = rowQ;
    assign rwHold[b]                   = (rcdQ != '0);
    assign actHold[b]                  = (preQ != '0);
  end

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BA_W         = 2,
  parameter int ADDR_W       = 13,
  parameter int ROW_W        = 13,
  parameter int AP_BIT       = 10,
  parameter int CLK_ACT2RW   = 3,
  parameter int CLK_ACT2ACT  = 2,
  parameter int CLK_PRE2ACT  = 3,
  parameter int CLK_MODE2CMD = 2,
  parameter int BURST_BEATS  = 4,
  localparam int BANKS       = 1 << BA_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   errClr,
  input  logic                   cke,
  input  logic                   csN,
  input  logic                   rasN,
  input  logic                   casN,
  input  logic                   weN,
  input  logic [BA_W-1:0]        ba,
  input  logic [ADDR_W-1:0]      addr,
  output logic [3:0]             cmdCode,
  output logic [BANKS-1:0]       bankActive,
  output logic [BANKS*ROW_W-1:0] openRow,
  output logic [ERR_KINDS-1:0]   errFlags,
  output logic [3:0]             errCode
);

  bank_strobe_t strb;
  logic [BANKS-1:0] rwHold;
  logic [BANKS-1:0] actHold;

  sdram_mon_ctrl #(
    .BANKS(BANKS), .BA_W(BA_W), .CLK_ACT2ACT(CLK_ACT2ACT),
    .CLK_MODE2CMD(CLK_MODE2CMD), .BURST_BEATS(BURST_BEATS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .errClr(errClr), .cke(cke), .csN(csN),
    .rasN(rasN), .casN(casN), .weN(weN), .ba(ba), .apBit(addr[AP_BIT]),
    .bankActive(bankActive), .rwHold(rwHold), .actHold(actHold),
    .strb(strb), .cmdCode(cmdCode), .errFlags(errFlags), .errCode(errCode)
  );

  sdram_mon_banks #(
    .BANKS(BANKS), .BA_W(BA_W), .ROW_W(ROW_W), .CLK_ACT2RW(CLK_ACT2RW),
    .CLK_PRE2ACT(CLK_PRE2ACT), .BURST_BEATS(BURST_BEATS)
  ) u_banks (
    .clk(clk), .rst_n(rst_n), .strb(strb), .ba(ba), .row(addr[ROW_W-1:0]),
    .bankActive(bankActive), .openRow(openRow), .rwHold(rwHold), .actHold(actHold)
  );

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk
  import sdram_mon_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int BA_W  = 2,
  parameter int ROW_W = 13
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   errClr,
  input logic                   cke,
  input logic                   csN,
  input logic                   rasN,
  input logic                   casN,
  input logic                   weN,
  input logic [BA_W-1:0]        ba,
  input logic                   apBit,
  input logic [3:0]             cmdCode,
  input logic [BANKS-1:0]       bankActive,
  input logic [BANKS*ROW_W-1:0] openRow,
  input logic [ERR_KINDS-1:0]   errFlags,
  input logic [3:0]             errCode
);

  logic sel, actCmd, rwCmd, preAllCmd;
  logic [BA_W-1:0] baQ;

  assign sel       = cke && !csN;
  assign actCmd    = sel && !rasN && casN && weN;
  assign rwCmd     = sel && rasN && !casN;
  assign preAllCmd = sel && !rasN && casN && !weN && apBit;

  always_ff @(posedge clk) baQ <= ba;

  assert_deselect_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (csN || !cke) |=> (cmdCode == 4'd8));

  assert_deselect_rows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (csN || !cke) |=> $stable(openRow));

  assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    actCmd |=> bankActive[baQ]);

  assert_pre_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    preAllCmd |=> (bankActive == '0));

  assert_idle_rw_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rwCmd && !bankActive[ba] && !errClr) |=> errFlags[ERR_RW_IDLE]);

  assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !errClr |=> ((errFlags & $past(errFlags)) == $past(errFlags)));

  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    errClr |=> ((errFlags == '0) && (errCode == '0)));

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(
  .BANKS(BANKS), .BA_W(BA_W), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .errClr(errClr), .cke(cke), .csN(csN),
  .rasN(rasN), .casN(casN), .weN(weN), .ba(ba), .apBit(addr[AP_BIT]),
  .cmdCode(cmdCode), .bankActive(bankActive), .openRow(openRow),
  .errFlags(errFlags), .errCode(errCode)
);

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 13;
  // Bench stimulus codes (0..7 are the command codes of R1).
  localparam int N = 0, M = 1, RF = 2, A = 3, RD = 4, WR = 5, P = 6, BS = 7;
  localparam int DS = 8;  // chip select high, activate pins
  localparam int CK = 9;  // clock enable low, read pins

  typedef struct {
    int    cmd;
    int    act;
    int    flags;
    int    code;
    int    rowBank;
    int    rowVal;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic errClr = 1'b0;
  logic cke = 1'b1, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0] ba = '0;
  logic [12:0] addr = '0;
  logic [3:0] cmdCode;
  logic [3:0] bankActive;
  logic [4*ROW_W-1:0] openRow;
  logic [7:0] errFlags;
  logic [3:0] errCode;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .errClr(errClr), .cke(cke), .csN(csN),
    .rasN(rasN), .casN(casN), .weN(weN), .ba(ba), .addr(addr),
    .cmdCode(cmdCode), .bankActive(bankActive), .openRow(openRow),
    .errFlags(errFlags), .errCode(errCode)
  );

  task automatic check(input string tag, input string field, input int got, input int want);
    checks++;
    if (got != want) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, field, got, want);
    end
  endtask

  task automatic step(input int c, input int b, input int a, input bit clr,
                      input int eAct, input int eFl, input int eCode,
                      input string tag, input int rb = -1, input int rv = 0);
    exp_t it;
    @(negedge clk);
    cke = 1'b1;
    csN = 1'b0;
    case (c)
      M:       {rasN, casN, weN} = 3'b000;
      RF:      {rasN, casN, weN} = 3'b001;
      A:       {rasN, casN, weN} = 3'b011;
      RD:      {rasN, casN, weN} = 3'b101;
      WR:      {rasN, casN, weN} = 3'b100;
      P:       {rasN, casN, weN} = 3'b010;
      BS:      {rasN, casN, weN} = 3'b110;
      DS: begin csN = 1'b1; {rasN, casN, weN} = 3'b011; end
      CK: begin cke = 1'b0; {rasN, casN, weN} = 3'b101; end
      default: {rasN, casN, weN} = 3'b111;
    endcase
    ba = 2'(b);
    addr = 13'(a);
    errClr = clr;
    it.cmd = (c >= DS) ? 8 : c;
    it.act = eAct;
    it.flags = eFl;
    it.code = eCode;
    it.rowBank = rb;
    it.rowVal = rv;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compares one expected item after each sampling edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t it;
        it = expQ.pop_front();
        check(it.tag, "cmdCode", int'(cmdCode), it.cmd);
        check(it.tag, "bankActive", int'(bankActive), it.act);
        check(it.tag, "errFlags", int'(errFlags), it.flags);
        check(it.tag, "errCode", int'(errCode), it.code);
        if (it.rowBank >= 0)
          check(it.tag, "openRow", int'(openRow[it.rowBank*ROW_W +: ROW_W]), it.rowVal);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // Reset state (R1, R12)
    check("R1 reset", "cmdCode", int'(cmdCode), 0);
    check("R12 reset", "errFlags", int'(errFlags), 0);
    check("R12 reset", "errCode", int'(errCode), 0);
    check("R3 reset", "bankActive", int'(bankActive), 0);
    rst_n = 1'b1;

    // Decoding and bank opening, boundaries met (R1 R3 R4 R8 R9 R10)
    step(N, 0, 0, 0, 4'b0000, 0, 0, "R1 nop");
    step(A, 2, 'h155, 0, 4'b0100, 0, 0, "R3 act bank2", 2, 'h155);
    step(N, 0, 0, 0, 4'b0100, 0, 0, "R1 nop");
    step(N, 0, 0, 0, 4'b0100, 0, 0, "R1 nop");
    step(RD, 2, 0, 0, 4'b0100, 0, 0, "R9 read at boundary");
    step(WR, 2, 0, 0, 4'b0100, 0, 0, "R1 write");
    step(BS, 0, 0, 0, 4'b0100, 0, 0, "R1 burst stop");
    step(P, 2, 0, 0, 4'b0000, 0, 0, "R4 single precharge");
    step(N, 0, 0, 0, 4'b0000, 0, 0, "R1 nop");
    step(N, 0, 0, 0, 4'b0000, 0, 0, "R1 nop");
    step(A, 2, 'h0AA, 0, 4'b0100, 0, 0, "R8 act at boundary", 2, 'h0AA);
    step(P, 0, 'h400, 0, 4'b0000, 0, 0, "R4 all precharge");
    step(N, 0, 0, 0, 4'b0000, 0, 0, "R1 nop");
    step(N, 0, 0, 0, 4'b0000, 0, 0, "R1 nop");
    step(A, 0, 1, 0, 4'b0001, 0, 0, "R3 act bank0", 0, 1);
    step(N, 0, 0, 0, 4'b0001, 0, 0, "R1 nop");
    step(A, 1, 2, 0, 4'b0011, 0, 0, "R10 act at boundary", 1, 2);
    step(N, 0, 0, 0, 4'b0011, 0, 0, "R1 nop");
    step(A, 3, 3, 0, 4'b1011, 0, 0, "R3 act bank3", 3, 3);
    step(N, 0, 0, 0, 4'b1011, 0, 0, "R1 nop");
    step(P, 1, 0, 0, 4'b1001, 0, 0, "R4 single bank1");
    step(P, 0, 'h400, 0, 4'b0000, 0, 0, "R4 all precharge");
    step(N, 0, 0, 0, 4'b0000, 0, 0, "R1 nop");
    step(N, 0, 0, 0, 4'b0000, 0, 0, "R1 nop");

    // Ignored pins (R2)
    step(DS, 0, 'h1FFF, 0, 4'b0000, 0, 0, "R2 chip select high", 0, 1);
    step(CK, 1, 0, 0, 4'b0000, 0, 0, "R2 clock enable low");

    // Idle and double activation (R11), clear (R12)
    step(RD, 1, 0, 0, 4'b0000, 'h40, 7, "R11 read idle bank");
    step(N, 0, 0, 1, 4'b0000, 0, 0, "R12 clear");
    step(A, 1, 5, 0, 4'b0010, 0, 0, "R3 act bank1", 1, 5);
    step(N, 0, 0, 0, 4'b0010, 0, 0, "R1 nop");
    step(N, 0, 0, 0, 4'b0010, 0, 0, "R1 nop");
    step(A, 1, 6, 0, 4'b0010, 'h80, 8, "R11 act open bank");
    step(N, 0, 0, 1, 4'b0010, 0, 0, "R12 clear");
    step(P, 0, 'h400, 0, 4'b0000, 0, 0, "R4 all precharge");
    step(N, 0, 0, 0, 4'b0000, 0, 0, "R1 nop");
    step(N, 0, 0, 0, 4'b0000, 0, 0, "R1 nop");

    // Activate-to-column too early (R9)
    step(A, 0, 7, 0, 4'b0001, 0, 0, "R3 act bank0", 0, 7);
    step(N, 0, 0, 0, 4'b0001, 0, 0, "R1 nop");
    step(RD, 0, 0, 0, 4'b0001, 'h10, 5, "R9 read too early");
    step(N, 0, 0, 1, 4'b0001, 0, 0, "R12 clear");

    // Activate-to-activate too early (R10)
    step(A, 2, 8, 0, 4'b0101, 0, 0, "R3 act bank2");
    step(A, 3, 9, 0, 4'b1101, 'h20, 6, "R10 act too early");
    step(N, 0, 0, 1, 4'b1101, 0, 0, "R12 clear");

    // Precharge-to-activate too early (R8)
    step(P, 0, 'h400, 0, 4'b0000, 0, 0, "R4 all precharge");
    step(N, 0, 0, 0, 4'b0000, 0, 0, "R1 nop");
    step(A, 0, 10, 0, 4'b0001, 'h08, 4, "R8 act too early");
    step(N, 0, 0, 1, 4'b0001, 0, 0, "R12 clear");
    step(P, 0, 'h400, 0, 4'b0000, 0, 0, "R4 all precharge");
    step(N, 0, 0, 0, 4'b0000, 0, 0, "R1 nop");
    step(N, 0, 0, 0, 4'b0000, 0, 0, "R1 nop");

    // Refresh with an open bank (R5)
    step(A, 1, 11, 0, 4'b0010, 0, 0, "R3 act bank1");
    step(N, 0, 0, 0, 4'b0010, 0, 0, "R1 nop");
    step(RF, 0, 0, 0, 4'b0010, 'h01, 1, "R5 refresh while active");
    step(N, 0, 0, 1, 4'b0010, 0, 0, "R12 clear");
    step(P, 0, 'h400, 0, 4'b0000, 0, 0, "R4 all precharge");
    step(N, 0, 0, 0, 4'b0000, 0, 0, "R1 nop");
    step(N, 0, 0, 0, 4'b0000, 0, 0, "R1 nop");

    // Mode load gap (R6)
    step(M, 0, 0, 0, 4'b0000, 0, 0, "R6 mode load idle");
    step(N, 0, 0, 0, 4'b0000, 0, 0, "R6 nop in gap");
    step(A, 0, 12, 0, 4'b0001, 0, 0, "R6 act at boundary");
    step(P, 0, 'h400, 0, 4'b0000, 0, 0, "R4 all precharge");
    step(N, 0, 0, 0, 4'b0000, 0, 0, "R1 nop");
    step(N, 0, 0, 0, 4'b0000, 0, 0, "R1 nop");
    step(M, 0, 0, 0, 4'b0000, 0, 0, "R6 mode load");
    step(RF, 0, 0, 0, 4'b0000, 'h02, 2, "R6 refresh too early");
    step(N, 0, 0, 1, 4'b0000, 0, 0, "R12 clear");

    // Auto-precharge burst (R7, R8)
    step(A, 3, 'h33, 0, 4'b1000, 0, 0, "R3 act bank3", 3, 'h33);
    step(N, 0, 0, 0, 4'b1000, 0, 0, "R1 nop");
    step(N, 0, 0, 0, 4'b1000, 0, 0, "R1 nop");
    step(RD, 3, 'h400, 0, 4'b1000, 0, 0, "R7 read auto-precharge");
    step(WR, 3, 0, 0, 4'b1000, 'h04, 3, "R7 write inside burst");
    step(N, 0, 0, 1, 4'b1000, 0, 0, "R12 clear");
    step(N, 0, 0, 0, 4'b1000, 0, 0, "R7 burst last beat");
    step(N, 0, 0, 0, 4'b0000, 0, 0, "R7 bank idle after burst");
    step(A, 3, 'h44, 0, 4'b1000, 'h08, 4, "R8 act too early after burst");
    step(N, 0, 0, 1, 4'b1000, 0, 0, "R12 clear");
    step(P, 0, 'h400, 0, 4'b0000, 0, 0, "R4 all precharge");
    step(N, 0, 0, 0, 4'b0000, 0, 0, "R1 nop");

    @(negedge clk);
    csN = 1'b1;
    errClr = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule